// File: doc/BRIEF.md
# DMA Bus Request Arbiter

This block decides who drives the processor bus: the CPU or an external DMA master. The DMA master raises a request and may use the bus only while the grant is high. The CPU always has the lower priority. When a request is pending, the block asserts a hold to the CPU. It issues the grant once the CPU reports that its current bus cycle is finished. While the processor is powered down its bus drivers are already released, so a request is then granted without waiting for the CPU.

Each DMA session is bounded by a session timer with a programmable limit. If the master keeps the bus for the full limit, the block withdraws the grant and releases the CPU hold. It also raises a timeout error flag that stays set until reset. The master must drop its request before it can be granted again. A limit of zero turns the timer off.

Top module: `dma_bus_arbiter`

## Requirements
- R1: While the synchronous reset is high and at the first clock edge after it, the grant, the CPU hold and the timeout error are all low.
- R2: Outside power-down, a request that is sampled while the CPU reports busy raises the CPU hold at the next edge. The grant stays low until an edge samples the CPU idle indication high, and it rises at that edge.
- R3: Outside power-down, a request that is sampled together with the CPU idle indication raises both the grant and the CPU hold at that same edge.
- R4: In power-down, a sampled request raises the grant at that edge whatever the CPU idle indication shows.
- R5: The grant and the CPU hold fall at the first edge that samples the request low.
- R6: With a nonzero limit L, the grant stays high for at most L consecutive cycles. At the edge that ends the L-th cycle, the grant and the hold fall and the timeout error rises.
- R7: The timeout error stays high until reset. After a timeout, no new grant is issued until the request has been sampled low at least once.
- R8: A limit value of zero disables the timeout, so a session lasts as long as the request stays high.
- R9: If the request is sampled low in the same cycle in which the timer would expire, the release takes priority and the timeout error is not set.
- R10: A request withdrawn while the block is waiting for the CPU returns the block to idle without a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dma_req_i | input | 1 | Bus request from the DMA master |
| cpu_idle_i | input | 1 | CPU has no bus cycle in progress |
| pwr_down_i | input | 1 | Processor is in power-down |
| timeout_limit_i | input | CNT_W | Session length limit in cycles; 0 disables it |
| dma_gnt_o | output | 1 | Bus granted to the DMA master |
| cpu_hold_o | output | 1 | CPU must not start a new bus cycle |
| timeout_err_o | output | 1 | Sticky flag set when a session exceeded the limit |

## Verification
Two events can fall in the same cycle: the master withdrawing its request and the session timer reaching its limit. The bench provokes this by dropping the request exactly in the last cycle that the limit allows. It then requires that the grant falls through a normal release with the error flag still clear. The bench also provokes a power-down request while the CPU reports busy, and the grant must still follow at once. Every cycle is compared against a behavioural reference model.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
   typedef enum logic [1:0] {
      ARB_IDLE     = 2'd0,
      ARB_WAIT_CPU = 2'd1,
      ARB_GRANTED  = 2'd2,
      ARB_TIMEOUT  = 2'd3
   } arb_state_e;
endpackage

// File: rtl/dma_session_timer.sv
module dma_session_timer #(
   parameter int unsigned CNT_W      = 8,
   parameter bit          TIMEOUT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             active_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic [CNT_W-1:0] count_o,
   output logic             expire_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || !active_i)
         cnt_q <= '0;
      else if (cnt_q != CNT_MAX)
         cnt_q <= cnt_q + 1'b1;
   end

   assign count_o = cnt_q;

   generate
      if (TIMEOUT_EN) begin : g_timer
         logic [CNT_W:0] next_len;
         assign next_len = {1'b0, cnt_q} + 1'b1;
         assign expire_o = active_i && (limit_i != '0) && (next_len >= {1'b0, limit_i});
      end else begin : g_no_timer
         assign expire_o = 1'b0;
      end
   endgenerate

   // R8: a zero limit never expires
   p_zero_limit_r8: assert property (@(posedge clk) disable iff (rst)
      (limit_i == '0) |-> !expire_o);
endmodule

// File: rtl/dma_arb_fsm.sv
module dma_arb_fsm
   import dma_arb_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       req_i,
   input  logic       cpu_idle_i,
   input  logic       pwr_down_i,
   input  logic       expire_i,
   output arb_state_e state_o,
   output logic       err_o
);
   arb_state_e state_q, state_d;
   logic       err_q;
   logic       bus_free;

   assign bus_free = pwr_down_i || cpu_idle_i;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ARB_IDLE:
            if (req_i) state_d = bus_free ? ARB_GRANTED : ARB_WAIT_CPU;
         ARB_WAIT_CPU:
            if (!req_i)        state_d = ARB_IDLE;
            else if (bus_free) state_d = ARB_GRANTED;
         ARB_GRANTED:
            if (!req_i)        state_d = ARB_IDLE;
            else if (expire_i) state_d = ARB_TIMEOUT;
         ARB_TIMEOUT:
            if (!req_i)        state_d = ARB_IDLE;
         default:              state_d = ARB_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ARB_IDLE;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ARB_GRANTED && req_i && expire_i)
            err_q <= 1'b1;
      end
   end

   assign state_o = state_q;
   assign err_o   = err_q;

   // R4: power-down grants straight from idle
   p_pd_grant_r4: assert property (@(posedge clk) disable iff (rst)
      (state_q == ARB_IDLE && req_i && pwr_down_i) |=> (state_q == ARB_GRANTED));
   // R7: after timeout the request must drop before any new grant
   p_no_regrant_r7: assert property (@(posedge clk) disable iff (rst)
      (state_q == ARB_TIMEOUT && req_i) |=> (state_q == ARB_TIMEOUT));
   // R10: withdrawn request while waiting returns to idle
   p_wait_withdraw_r10: assert property (@(posedge clk) disable iff (rst)
      (state_q == ARB_WAIT_CPU && !req_i) |=> (state_q == ARB_IDLE));
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
   import dma_arb_pkg::*;
#(
   parameter int unsigned CNT_W      = 8,
   parameter bit          TIMEOUT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             dma_req_i,
   input  logic             cpu_idle_i,
   input  logic             pwr_down_i,
   input  logic [CNT_W-1:0] timeout_limit_i,
   output logic             dma_gnt_o,
   output logic             cpu_hold_o,
   output logic             timeout_err_o
);
   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_width
         $error("dma_bus_arbiter: CNT_W must be within 1..32");
      end
   endgenerate

   arb_state_e       state;
   logic             expire;
   logic             granted;
   logic [CNT_W-1:0] sess_cnt;

   assign granted = (state == ARB_GRANTED);

   dma_arb_fsm u_fsm (
      .clk        (clk),
      .rst        (rst),
      .req_i      (dma_req_i),
      .cpu_idle_i (cpu_idle_i),
      .pwr_down_i (pwr_down_i),
      .expire_i   (expire),
      .state_o    (state),
      .err_o      (timeout_err_o)
   );

   dma_session_timer #(
      .CNT_W      (CNT_W),
      .TIMEOUT_EN (TIMEOUT_EN)
   ) u_timer (
      .clk      (clk),
      .rst      (rst),
      .active_i (granted),
      .limit_i  (timeout_limit_i),
      .count_o  (sess_cnt),
      .expire_o (expire)
   );

   assign dma_gnt_o  = granted;
   assign cpu_hold_o = (state == ARB_WAIT_CPU) || granted;

   // R2: a grant only ever comes with the CPU held
   p_gnt_holds_cpu_r2: assert property (@(posedge clk) disable iff (rst)
      dma_gnt_o |-> cpu_hold_o);
   // R5: a sampled low request removes the grant at the next edge
   p_release_r5: assert property (@(posedge clk) disable iff (rst)
      (dma_gnt_o && !dma_req_i) |=> !dma_gnt_o);
   // R6: the session counter stays below a nonzero limit while granted
   p_bound_r6: assert property (@(posedge clk) disable iff (rst)
      (dma_gnt_o && timeout_limit_i != '0) |-> (sess_cnt < timeout_limit_i));
   // R7: the error flag is sticky
   p_sticky_err_r7: assert property (@(posedge clk) disable iff (rst)
      timeout_err_o |=> timeout_err_o);
   // R3: a rising grant always answers a sampled request
   p_gnt_needs_req_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(dma_gnt_o) |-> $past(dma_req_i));
endmodule

// File: tb/dma_bus_arbiter_tb.sv
module dma_bus_arbiter_tb;
   localparam int CNT_W = 8;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             req = 1'b0;
   logic             idle = 1'b1;
   logic             pd = 1'b0;
   logic [CNT_W-1:0] lim = '0;
   logic             gnt, hold, err;

   int    checks = 0;
   int    fails  = 0;
   int    cycles = 0;
   bit    cmp_en = 1'b0;
   bit    done   = 1'b0;
   string tag    = "R1";

   // behavioural reference: owner 0 cpu, 1 waiting, 2 dma, 3 locked out
   int m_own = 0;
   int m_len = 0;
   bit m_err = 1'b0;

   always #2 clk = ~clk;

   dma_bus_arbiter #(.CNT_W(CNT_W), .TIMEOUT_EN(1'b1)) u_dut (
      .clk             (clk),
      .rst             (rst),
      .dma_req_i       (req),
      .cpu_idle_i      (idle),
      .pwr_down_i      (pd),
      .timeout_limit_i (lim),
      .dma_gnt_o       (gnt),
      .cpu_hold_o      (hold),
      .timeout_err_o   (err)
   );

   always @(posedge clk) begin
      cycles++;
      if (rst) begin
         m_own = 0; m_len = 0; m_err = 1'b0;
      end else begin
         case (m_own)
            0: if (req) begin m_own = (pd || idle) ? 2 : 1; m_len = 0; end
            1: if (!req) m_own = 0;
               else if (pd || idle) begin m_own = 2; m_len = 0; end
            2: if (!req) m_own = 0;
               else if (lim != 0 && m_len + 1 >= int'(lim)) begin m_own = 3; m_err = 1'b1; end
               else m_len++;
            default: if (!req) m_own = 0;
         endcase
      end
   end

   task automatic check(input bit ok, input string t, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_en && !done) begin
         check(gnt  == (m_own == 2), tag, "grant", gnt, m_own == 2);
         check(hold == (m_own == 1 || m_own == 2), tag, "hold", hold, m_own == 1 || m_own == 2);
         check(err  == m_err, tag, "error", err, m_err);
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      wait (cycles > 5000);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      finish_run();
   end

   initial begin
      step(3);
      tag = "R1";
      check(gnt == 0 && hold == 0 && err == 0, "R1", "reset outputs", {gnt, hold, err}, 0);
      rst = 1'b0;
      cmp_en = 1'b1;
      step(2);

      tag = "R3"; idle = 1'b1; req = 1'b1; step(1);
      check(gnt == 1, "R3", "grant at first edge", gnt, 1);
      step(3);
      tag = "R5"; req = 1'b0; step(1);
      check(gnt == 0 && hold == 0, "R5", "release", {gnt, hold}, 0);
      step(2);

      tag = "R2"; idle = 1'b0; req = 1'b1; step(1);
      check(hold == 1 && gnt == 0, "R2", "hold without grant", {hold, gnt}, 2);
      step(4); idle = 1'b1; step(1);
      check(gnt == 1, "R2", "grant after idle", gnt, 1);
      step(2); req = 1'b0; step(2);

      tag = "R10"; idle = 1'b0; req = 1'b1; step(2); req = 1'b0; step(1);
      check(hold == 0 && gnt == 0, "R10", "withdraw while waiting", {hold, gnt}, 0);
      step(2);

      tag = "R4"; pd = 1'b1; idle = 1'b0; req = 1'b1; step(1);
      check(gnt == 1, "R4", "power-down grant", gnt, 1);
      step(3); req = 1'b0; step(2); pd = 1'b0; idle = 1'b1;

      tag = "R8"; lim = '0; req = 1'b1; step(40);
      check(gnt == 1 && err == 0, "R8", "no timeout at zero limit", {gnt, err}, 2);
      req = 1'b0; step(2);

      tag = "R9"; lim = 8'd4; req = 1'b1; step(4); req = 1'b0; step(1);
      check(gnt == 0 && err == 0, "R9", "release beats expiry", {gnt, err}, 0);
      step(2);

      tag = "R6"; lim = 8'd5; req = 1'b1; step(5);
      check(gnt == 1, "R6", "grant in last allowed cycle", gnt, 1);
      step(1);
      check(gnt == 0 && hold == 0 && err == 1, "R6", "timeout", {gnt, hold, err}, 1);

      tag = "R7"; step(6);
      check(gnt == 0 && err == 1, "R7", "locked out while request held", {gnt, err}, 1);
      req = 1'b0; step(1); req = 1'b1; step(1);
      check(gnt == 1 && err == 1, "R7", "regrant after drop, error kept", {gnt, err}, 3);
      req = 1'b0; step(3);

      cmp_en = 1'b0; rst = 1'b1; step(1);
      check(err == 0 && gnt == 0, "R1", "reset clears error", {err, gnt}, 0);
      rst = 1'b0; step(1);
      check(err == 0 && gnt == 0 && hold == 0, "R1", "first cycle after reset", {err, gnt, hold}, 0);

      finish_run();
   end
endmodule